// File: doc/BRIEF.md
# Timer Channel-Pair Trigger Router

This block sits beside one even/odd pair of timer channels and decides where each channel's combined clock/trigger/measure input comes from. A 3-bit mode field chooses between a shared external pin, a cascade signal handed up from the pair below, the even channel's own waveform, or one-cycle pulses produced by a software start write. The router also carries each channel's waveform to its output pin, and it produces a cascade output for the pair above.

Pairs are chained by wiring one pair's cascade output to the next pair's cascade input. The cascade path is combinational through every pair that selects cascade mode. One synchronized pin edge, or one software write, therefore reaches four or more channels on the same clock edge. Pair 0 has no pair below it, and it treats the cascade selection as invalid. The counters themselves live outside this block.

Top module: `tpr_pair_router`

## Requirements
- R1: While reset is asserted, the synchronizer and software pulse registers are cleared, so with mode 2 selected the even source, the odd source and the cascade output all read 0, even when both pins are held high.
- R2: Mode 2 (shared pin): the even pin, delayed by exactly two clock edges, drives the even source, the odd source and the cascade output. The odd pin has no effect.
- R3: Mode 3 (shared cascade), on a pair with index 1 or more: the cascade input drives the even source, the odd source and the cascade output in the same cycle, with no register on the path. Both pins are ignored.
- R4: On pair index 0, mode 3 is invalid and behaves exactly as the pass-through of R10.
- R5: Mode 4 (start/stop): the even pin, delayed by two edges, drives only the even source. The even waveform input drives the odd source, the odd stop output and the cascade output.
- R6: Mode 5 (software simultaneous start): a write cycle with mask bit 0 (even) or mask bit 1 (odd) set raises that channel's source for exactly the one cycle after the write edge. Every bit set in one write rises in the same cycle.
- R7: Mode 6 (software start with start/stop): mask bit 0 of a write pulses the even source for one cycle, and mask bit 1 has no effect. The odd source, the odd stop output and the cascade output follow the even waveform input.
- R8: In every mode, output pin A of the even channel equals the even waveform input, and output pin A of the odd channel equals the odd waveform input.
- R9: In the software modes, a channel source with no write in the previous cycle rests at 0.
- R10: Encodings 0, 1 and 7 select pass-through: each pin, delayed by two edges, feeds its own channel source. The odd stop output and the cascade output are 0.
- R11: The odd stop output is 0 in every mode other than 4 and 6.
- R12: In mode 5 the cascade output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Routing mode select |
| pin_b_even | input | 1 | Asynchronous input pin of the even channel |
| pin_b_odd | input | 1 | Asynchronous input pin of the odd channel |
| wave_even | input | 1 | Waveform output of the even channel |
| wave_odd | input | 1 | Waveform output of the odd channel |
| casc_in | input | 1 | Cascade signal from the pair below |
| sw_wr | input | 1 | Software start write strobe, one cycle per write |
| sw_mask | input | 2 | Start bits of the write (bit 0 even, bit 1 odd) |
| even_src | output | 1 | Clock/trigger/measure input of the even channel |
| odd_src | output | 1 | Clock/trigger/measure input of the odd channel |
| odd_stop | output | 1 | Stop-trigger input of the odd channel |
| pin_a_even | output | 1 | Output pin of the even channel waveform |
| pin_a_odd | output | 1 | Output pin of the odd channel waveform |
| casc_out | output | 1 | Cascade signal to the pair above |

## Verification
Some properties are checked by assertions on every cycle:
- the two-edge synchronizer delay;
- the one-cycle width and mask copy of the software pulses;
- the combinational cascade pass in mode 3 and the following of the even waveform in mode 4;
- the stop output resting low outside the start/stop modes;
- pair 0 refusing the cascade mode.

Other behaviour only the bench scenarios can show. The bench chains a pair-0 router below a pair-1 router, so it can check that one pin edge reaches all four channel sources on the same edge and that one write starts all four. It also covers reset with high pins, the odd pin being ignored, and long random mode changes with random pins, waveforms and writes.

// File: rtl/tpr_pkg.sv
package tpr_pkg;

  typedef enum logic [2:0] {
    M_PASS         = 3'd0,
    M_SHR_PIN      = 3'd2,
    M_SHR_CASC     = 3'd3,
    M_START_STOP   = 3'd4,
    M_SW_SIMUL     = 3'd5,
    M_SW_STARTSTOP = 3'd6
  } tpr_mode_e;

  typedef struct packed {
    logic even_src;
    logic odd_src;
    logic odd_stop;
    logic casc;
  } tpr_route_t;

  function automatic tpr_mode_e tpr_decode(input logic [2:0] m, input logic is_pair0);
    case (m)
      3'd2:    return M_SHR_PIN;
      3'd3:    return is_pair0 ? M_PASS : M_SHR_CASC;
      3'd4:    return M_START_STOP;
      3'd5:    return M_SW_SIMUL;
      3'd6:    return M_SW_STARTSTOP;
      default: return M_PASS;
    endcase
  endfunction

endpackage

// File: rtl/tpr_sync.sv
module tpr_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int WW = $clog2(STAGES + 1);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = din;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
    end
  end

  assign dout = stage_q[STAGES-1];

  // warm-up counter for the checker only
  logic [WW-1:0] warm_q, warm_d;
  always_comb warm_d = (warm_q == WW'(STAGES)) ? warm_q : warm_q + 1'b1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else        warm_q <= warm_d;
  end

  // R2: output equals the input from STAGES edges earlier
  assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == WW'(STAGES)) |-> (dout == $past(din, STAGES)));

endmodule

// File: rtl/tpr_sw_pulse.sv
module tpr_sw_pulse #(
  parameter int CH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_wr,
  input  logic [CH-1:0] sw_mask,
  output logic [CH-1:0] pulse
);
  logic [CH-1:0] pulse_q, pulse_d;

  always_comb pulse_d = sw_wr ? sw_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= '0;
    else        pulse_q <= pulse_d;
  end

  assign pulse = pulse_q;

  assert_pulse_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr |=> (pulse_q == '0));

  assert_pulse_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> (pulse_q == $past(sw_mask)));

endmodule

// File: rtl/tpr_route_mux.sv
module tpr_route_mux
  import tpr_pkg::*;
(
  input  tpr_mode_e  mode,
  input  logic       pin_e_s,
  input  logic       pin_o_s,
  input  logic       casc_in,
  input  logic       wave_even,
  input  logic [1:0] sw_pulse,
  output tpr_route_t route
);
  always_comb begin
    route = '0;
    case (mode)
      M_SHR_PIN: begin
        route.even_src = pin_e_s;
        route.odd_src  = pin_e_s;
        route.casc     = pin_e_s;
      end
      M_SHR_CASC: begin
        route.even_src = casc_in;
        route.odd_src  = casc_in;
        route.casc     = casc_in;
      end
      M_START_STOP: begin
        route.even_src = pin_e_s;
        route.odd_src  = wave_even;
        route.odd_stop = wave_even;
        route.casc     = wave_even;
      end
      M_SW_SIMUL: begin
        route.even_src = sw_pulse[0];
        route.odd_src  = sw_pulse[1];
      end
      M_SW_STARTSTOP: begin
        route.even_src = sw_pulse[0];
        route.odd_src  = wave_even;
        route.odd_stop = wave_even;
        route.casc     = wave_even;
      end
      default: begin
        route.even_src = pin_e_s;
        route.odd_src  = pin_o_s;
      end
    endcase
  end
endmodule

// File: rtl/tpr_pair_router.sv
module tpr_pair_router
  import tpr_pkg::*;
#(
  parameter int PAIR_IDX    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_sel,
  input  logic       pin_b_even,
  input  logic       pin_b_odd,
  input  logic       wave_even,
  input  logic       wave_odd,
  input  logic       casc_in,
  input  logic       sw_wr,
  input  logic [1:0] sw_mask,
  output logic       even_src,
  output logic       odd_src,
  output logic       odd_stop,
  output logic       pin_a_even,
  output logic       pin_a_odd,
  output logic       casc_out
);
  localparam logic IS_PAIR0 = (PAIR_IDX == 0);

  logic [1:0] pin_s;
  logic [1:0] sw_pulse;
  tpr_mode_e  mode_eff;
  tpr_route_t route;

  tpr_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk (clk), .rst_n (rst_n),
    .din ({pin_b_odd, pin_b_even}), .dout (pin_s)
  );

  tpr_sw_pulse #(.CH(2)) u_sw (
    .clk (clk), .rst_n (rst_n),
    .sw_wr (sw_wr), .sw_mask (sw_mask), .pulse (sw_pulse)
  );

  always_comb mode_eff = tpr_decode(mode_sel, IS_PAIR0);

  tpr_route_mux u_mux (
    .mode (mode_eff), .pin_e_s (pin_s[0]), .pin_o_s (pin_s[1]),
    .casc_in (casc_in), .wave_even (wave_even), .sw_pulse (sw_pulse),
    .route (route)
  );

  assign even_src   = route.even_src;
  assign odd_src    = route.odd_src;
  assign odd_stop   = route.odd_stop;
  assign casc_out   = route.casc;
  assign pin_a_even = wave_even;
  assign pin_a_odd  = wave_odd;

  assert_casc_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 3'd3 && !IS_PAIR0) |->
      (even_src == casc_in && odd_src == casc_in && casc_out == casc_in));

  assert_startstop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 3'd4) |->
      (odd_src == wave_even && odd_stop == wave_even && casc_out == wave_even));

  assert_stop_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 3'd4 && mode_sel != 3'd6) |-> !odd_stop);

  generate
    if (PAIR_IDX == 0) begin : g_pair0_chk
      assert_pair0_no_casc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd3) |-> (!casc_out && !odd_stop));
    end
  endgenerate

endmodule

// File: tb/tpr_pair_router_bench.sv
`timescale 1ns/1ps
module tpr_pair_router_bench;

  typedef struct packed {
    logic ev; logic od; logic st; logic cc;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic [2:0] mode_lo, mode_hi;
  logic pe_lo, po_lo, pe_hi, po_hi;
  logic we_lo, wo_lo, we_hi, wo_hi;
  logic casc_lo_in;
  logic sw_wr;
  logic [3:0] sw_mask;

  logic ev_lo, od_lo, st_lo, pae_lo, pao_lo, cc_lo;
  logic ev_hi, od_hi, st_hi, pae_hi, pao_hi, cc_hi;

  tpr_pair_router #(.PAIR_IDX(0)) u_tpr_pair_router_lo (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_lo), .pin_b_even(pe_lo), .pin_b_odd(po_lo),
    .wave_even(we_lo), .wave_odd(wo_lo), .casc_in(casc_lo_in), .sw_wr(sw_wr),
    .sw_mask(sw_mask[1:0]), .even_src(ev_lo), .odd_src(od_lo), .odd_stop(st_lo),
    .pin_a_even(pae_lo), .pin_a_odd(pao_lo), .casc_out(cc_lo));

  tpr_pair_router #(.PAIR_IDX(1)) u_tpr_pair_router (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_hi), .pin_b_even(pe_hi), .pin_b_odd(po_hi),
    .wave_even(we_hi), .wave_odd(wo_hi), .casc_in(cc_lo), .sw_wr(sw_wr),
    .sw_mask(sw_mask[3:2]), .even_src(ev_hi), .odd_src(od_hi), .odd_stop(st_hi),
    .pin_a_even(pae_hi), .pin_a_odd(pao_hi), .casc_out(cc_hi));

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model state: two-edge pin delay and software pulse
  logic [3:0] s1, s2;
  logic [3:0] swp;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 = '0; s2 = '0; swp = '0;
    end else begin
      s2 = s1;
      s1 = {po_hi, pe_hi, po_lo, pe_lo};
      swp = sw_wr ? sw_mask : 4'b0;
    end
  end

  function automatic exp_t exp_route(input logic [2:0] m, input bit p0, input logic se,
                                     input logic so, input logic ci, input logic we,
                                     input logic [1:0] sp);
    exp_t r = '0;
    if (m == 3'd3 && p0) m = 3'd0;                // R4
    case (m)
      3'd2: begin r.ev = se; r.od = se; r.cc = se; end
      3'd3: begin r.ev = ci; r.od = ci; r.cc = ci; end
      3'd4: begin r.ev = se; r.od = we; r.st = we; r.cc = we; end
      3'd5: begin r.ev = sp[0]; r.od = sp[1]; end
      3'd6: begin r.ev = sp[0]; r.od = we; r.st = we; r.cc = we; end
      default: begin r.ev = se; r.od = so; end
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [2:0] m, input bit p0);
    case (m)
      3'd2: return "R2";
      3'd3: return p0 ? "R4" : "R3";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic check_pair(input string nm, input logic [2:0] m, input bit p0,
                            input exp_t e, input logic ev, input logic od,
                            input logic st, input logic cc, input logic sp_any);
    string t = tag_of(m, p0);
    string tsw = (m == 3'd5 && !sp_any) ? "R9" : t;
    chk(tsw, {nm, " even_src"}, ev, e.ev);
    chk(tsw, {nm, " odd_src"}, od, e.od);
    chk((m == 3'd4 || m == 3'd6) ? t : "R11", {nm, " odd_stop"}, st, e.st);
    chk((m == 3'd5) ? "R12" : t, {nm, " casc_out"}, cc, e.cc);
  endtask

  task automatic check_all();
    exp_t el, eh;
    el = exp_route(mode_lo, 1'b1, s2[0], s2[1], casc_lo_in, we_lo, swp[1:0]);
    eh = exp_route(mode_hi, 1'b0, s2[2], s2[3], el.cc, we_hi, swp[3:2]);
    check_pair("lo", mode_lo, 1'b1, el, ev_lo, od_lo, st_lo, cc_lo, |swp[1:0]);
    check_pair("hi", mode_hi, 1'b0, eh, ev_hi, od_hi, st_hi, cc_hi, |swp[3:2]);
    chk("R8", "lo pin_a_even", pae_lo, we_lo);
    chk("R8", "lo pin_a_odd", pao_lo, wo_lo);
    chk("R8", "hi pin_a_even", pae_hi, we_hi);
    chk("R8", "hi pin_a_odd", pao_hi, wo_hi);
  endtask

  task automatic next_cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    mode_lo = 3'd2; mode_hi = 3'd2;
    pe_lo = 1; po_lo = 1; pe_hi = 1; po_hi = 1;
    we_lo = 0; wo_lo = 0; we_hi = 0; wo_hi = 0;
    casc_lo_in = 0; sw_wr = 0; sw_mask = '0;
    repeat (3) next_cycle();
    // R1: reset holds derived sources low with pins high
    chk("R1", "lo even_src in reset", ev_lo, 1'b0);
    chk("R1", "lo odd_src in reset", od_lo, 1'b0);
    chk("R1", "hi casc_out in reset", cc_hi, 1'b0);
    chk("R1", "hi even_src in reset", ev_hi, 1'b0);

    // R2/R3: one pin edge reaches four channels on the same edge
    pe_lo = 1'b1; po_lo = 1'b0; mode_hi = 3'd3;
    rst_n = 1'b1;
    next_cycle(); #1;
    chk("R2", "lo even_src after one edge", ev_lo, 1'b0);
    chk("R3", "hi even_src after one edge", ev_hi, 1'b0);
    next_cycle(); #1;
    chk("R2", "lo even_src after two edges", ev_lo, 1'b1);
    chk("R2", "lo odd_src follows even pin", od_lo, 1'b1);
    chk("R3", "hi even_src via cascade", ev_hi, 1'b1);
    chk("R3", "hi odd_src via cascade", od_hi, 1'b1);
    check_all();

    // R6: one write starts all four channels together for one cycle
    mode_lo = 3'd5; mode_hi = 3'd5; sw_wr = 1'b1; sw_mask = 4'b1111;
    next_cycle(); sw_wr = 1'b0; sw_mask = 4'b0; #1;
    chk("R6", "four sources high after write",
        logic'(ev_lo & od_lo & ev_hi & od_hi), 1'b1);
    check_all();
    next_cycle(); #1;
    chk("R6", "sources back low next cycle",
        logic'(ev_lo | od_lo | ev_hi | od_hi), 1'b0);
    check_all();

    // R7: odd mask bit has no effect in mode 6
    mode_lo = 3'd6; we_lo = 1'b0; sw_wr = 1'b1; sw_mask = 4'b0010;
    next_cycle(); sw_wr = 1'b0; sw_mask = 4'b0; #1;
    chk("R7", "odd bit write leaves odd_src low", od_lo, 1'b0);
    chk("R7", "odd bit write leaves even_src low", ev_lo, 1'b0);
    check_all();

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      if (i % 16 == 0) begin
        mode_lo = 3'($urandom_range(0, 7));
        mode_hi = 3'($urandom_range(0, 7));
      end
      pe_lo = 1'($urandom); po_lo = 1'($urandom);
      pe_hi = 1'($urandom); po_hi = 1'($urandom);
      we_lo = 1'($urandom); wo_lo = 1'($urandom);
      we_hi = 1'($urandom); wo_hi = 1'($urandom);
      casc_lo_in = 1'($urandom);
      sw_wr = ($urandom_range(0, 3) == 0);
      sw_mask = 4'($urandom);
      #1;
      check_all();
      next_cycle();
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule